// File: doc/BRIEF.md
# Configurable Parallel Host Bus Front-End

This block sits between the pins of a slave parallel host port and the register logic behind it. A run-time control register reshapes the external protocol. It sets the active level of chip select, address strobe and data strobes. It chooses one combined data strobe with a direction pin, or separate read and write strobes. It takes the register address either from dedicated address pins or from an internal latch that captures the low part of a shared address/data bus. It also chooses push-pull or open-drain drive for one or two request outputs.

All pin inputs pass through a two-flop synchronizer. Each access is reported inside the chip as a single-cycle read or write pulse, together with the register address captured for that access. When the port is disabled, every port pin becomes a general-purpose pin. Its output enable and output value then come from a direction register and a data register, and its synchronized level is always readable.

Pin map of `pad_i`/`pad_o`/`pad_oe_o`: bit 0 chip select, bit 1 address strobe, bit 2 data strobe (read strobe in dual mode), bit 3 write strobe (dual mode only), bit 4 direction (1 read, 0 write), and bits 5 and up the dedicated address.

Top module: `host_bus_frontend`

## Requirements
- R1: After reset the control, direction and data registers are all 0. The port is disabled, `pad_oe_o`, `pad_o`, `rd_o`, `wr_o`, `addr_o` and both request enables are 0.
- R2: Chip select is active when `pad_i[0]` equals control bit 1 (0 active low, 1 active high). No pulse is produced while chip select is inactive.
- R3: With control bit 4 at 0, the strobe on `pad_i[2]` plus `pad_i[4]`=1 gives a read pulse, and plus `pad_i[4]`=0 gives a write pulse.
- R4: With control bit 4 at 1, `pad_i[2]` is the read strobe and `pad_i[3]` the write strobe, and `pad_i[4]` is ignored.
- R5: A data strobe is active when its pin equals control bit 3 (0 active low, 1 active high). This applies to the single strobe and to both dual strobes.
- R6: When chip select and a strobe both become active, `rd_o` or `wr_o` is high for exactly one cycle. The pulse appears at the third rising clock edge after the pin change: two synchronizer stages, then one output register.
- R7: With control bit 5 at 0, `addr_o` takes the synchronized `pad_i[5 +: ADDR_W]` at each pulse and holds it until the next pulse.
- R8: With control bit 5 at 1, an internal latch follows the synchronized `ad_lo_i` while the address strobe is active. The strobe is active when `pad_i[1]` equals control bit 2. The latch holds its value after the strobe deasserts, and `addr_o` takes the latch value at each pulse.
- R9: Requests are driven only when control bit 0 (port enable) and control bit 7 (request enable) are both 1. In push-pull mode (control bit 6 at 0), a used line has its enable at 1 and its output at the inverted request, so it is active low. Otherwise the enable is 0.
- R10: In open-drain mode (control bit 6 at 1), each used line has its output fixed at 0. Its enable is 1 only while its request is active.
- R11: With control bit 8 at 0, only `treq_*` is used and it carries `tx_req_i | rx_req_i`; `rreq_oe_o` stays 0. With control bit 8 at 1, `treq_*` carries `tx_req_i` and `rreq_*` carries `rx_req_i`.
- R12: While control bit 0 is 0, `pad_oe_o` equals the direction register, `pad_o` equals the data register, and no pulse occurs. `pad_in_o` always shows `pad_i` two clock edges late.
- R13: A write with `cfg_we_i` loads `cfg_wdata_i` at the next edge. `cfg_sel_i` selects the target: 0 for the control register (bits 8:0), 1 for direction, 2 for data. Code 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Register select: 0 control, 1 direction, 2 data |
| cfg_wdata_i | input | CFG_DW | Configuration write data |
| pad_i | input | NPAD | Port pin levels |
| ad_lo_i | input | ADDR_W | Low bits of the shared address/data bus |
| pad_o | output | NPAD | Pin output value in general-purpose mode |
| pad_oe_o | output | NPAD | Pin output enable in general-purpose mode |
| pad_in_o | output | NPAD | Synchronized pin levels |
| tx_req_i | input | 1 | Transmit request from the core side |
| rx_req_i | input | 1 | Receive request from the core side |
| treq_o | output | 1 | Request line 0 output value |
| treq_oe_o | output | 1 | Request line 0 output enable |
| rreq_o | output | 1 | Request line 1 output value |
| rreq_oe_o | output | 1 | Request line 1 output enable |
| rd_o | output | 1 | Single-cycle read pulse |
| wr_o | output | 1 | Single-cycle write pulse |
| addr_o | output | ADDR_W | Register address of the latest access |

## Verification
The assertions assume that the host never asserts the read and write strobes together in dual-strobe mode. They also assume that polarity and strobe-style changes happen only while the port is disabled, so that a mode switch cannot look like a new strobe edge. The stimulus follows these rules. It first writes the control word with the enable bit clear, then drives idle pin levels that match the new polarities, and only then enables the port. Each access holds a strobe for several cycles and releases it before the next one, so every pulse comes from a single clean edge.

// File: rtl/hbf_pkg.sv
package hbf_pkg;
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_DIR  = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;

  localparam int PAD_CS   = 0;
  localparam int PAD_AS   = 1;
  localparam int PAD_DS   = 2;
  localparam int PAD_WR   = 3;
  localparam int PAD_RW   = 4;
  localparam int PAD_ADDR = 5;

  localparam int CTRL_W = 9;

  // bit 0 at the bottom
  typedef struct packed {
    logic dbl_req;
    logic req_en;
    logic req_od;
    logic mux;
    logic dual;
    logic ds_pol;
    logic as_pol;
    logic cs_pol;
    logic port_en;
  } ctrl_t;
endpackage

// File: rtl/hbf_cfg_regs.sv
module hbf_cfg_regs
  import hbf_pkg::*;
#(
  parameter int NPAD   = 8,
  parameter int CFG_DW = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [CFG_DW-1:0] wdata_i,
  output ctrl_t             ctrl_o,
  output logic [NPAD-1:0]   dir_o,
  output logic [NPAD-1:0]   data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
      dir_o  <= '0;
      data_o <= '0;
    end else if (we_i) begin
      unique case (sel_i)
        SEL_CTRL: ctrl_o <= ctrl_t'(wdata_i[CTRL_W-1:0]);
        SEL_DIR:  dir_o  <= wdata_i[NPAD-1:0];
        SEL_DATA: data_o <= wdata_i[NPAD-1:0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/hbf_sync.sv
module hbf_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else            stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/hbf_strobe_decode.sv
module hbf_strobe_decode
  import hbf_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int NPAD  = PAD_ADDR + ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              port_en_i,
  input  logic              cs_pol_i,
  input  logic              as_pol_i,
  input  logic              ds_pol_i,
  input  logic              dual_i,
  input  logic              mux_i,
  input  logic [NPAD-1:0]   pad_s_i,
  input  logic [ADDR_W-1:0] ad_s_i,
  output logic              rd_o,
  output logic              wr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] latch_o,
  output logic              as_act_o
);
  logic cs_act, ds_act, wrs_act, rd_act, wr_act, rd_q, wr_q, rd_edge, wr_edge;
  logic [ADDR_W-1:0] addr_sel;

  assign cs_act   = port_en_i & (pad_s_i[PAD_CS] == cs_pol_i);
  assign as_act_o = port_en_i & mux_i & (pad_s_i[PAD_AS] == as_pol_i);
  assign ds_act   = (pad_s_i[PAD_DS] == ds_pol_i);
  assign wrs_act  = (pad_s_i[PAD_WR] == ds_pol_i);

  always_comb begin
    if (dual_i) begin
      rd_act = cs_act & ds_act;
      wr_act = cs_act & wrs_act;
    end else begin
      rd_act = cs_act & ds_act & pad_s_i[PAD_RW];
      wr_act = cs_act & ds_act & ~pad_s_i[PAD_RW];
    end
  end

  assign rd_edge  = rd_act & ~rd_q;
  assign wr_edge  = wr_act & ~wr_q;
  assign addr_sel = mux_i ? latch_o : pad_s_i[PAD_ADDR +: ADDR_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      rd_o    <= 1'b0;
      wr_o    <= 1'b0;
      addr_o  <= '0;
      latch_o <= '0;
    end else begin
      rd_q <= rd_act;
      wr_q <= wr_act;
      rd_o <= rd_edge;
      wr_o <= wr_edge;
      if (rd_edge | wr_edge) addr_o <= addr_sel;
      // transparent while strobe active, closes on deassert
      if (as_act_o) latch_o <= ad_s_i;
    end
  end
endmodule

// File: rtl/hbf_req_drive.sv
module hbf_req_drive #(
  parameter int NLINE = 2
) (
  input  logic             port_en_i,
  input  logic             req_en_i,
  input  logic             req_od_i,
  input  logic             dbl_req_i,
  input  logic             tx_req_i,
  input  logic             rx_req_i,
  output logic [NLINE-1:0] req_o,
  output logic [NLINE-1:0] req_oe_o
);
  logic             drive;
  logic [NLINE-1:0] act, used;

  assign drive = port_en_i & req_en_i;

  for (genvar i = 0; i < NLINE; i++) begin : g_line
    if (i == 0) begin : g_tx
      assign act[i]  = dbl_req_i ? tx_req_i : (tx_req_i | rx_req_i);
      assign used[i] = 1'b1;
    end else begin : g_rx
      assign act[i]  = rx_req_i;
      assign used[i] = dbl_req_i;
    end
    assign req_oe_o[i] = drive & used[i] & (req_od_i ? act[i] : 1'b1);
    assign req_o[i]    = drive & used[i] & ~req_od_i & ~act[i];
  end
endmodule

// File: rtl/host_bus_frontend.sv
module host_bus_frontend
  import hbf_pkg::*;
#(
  parameter int ADDR_W  = 3,
  localparam int NPAD   = PAD_ADDR + ADDR_W,
  localparam int CFG_DW = (NPAD > CTRL_W) ? NPAD : CTRL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [CFG_DW-1:0] cfg_wdata_i,
  input  logic [NPAD-1:0]   pad_i,
  input  logic [ADDR_W-1:0] ad_lo_i,
  output logic [NPAD-1:0]   pad_o,
  output logic [NPAD-1:0]   pad_oe_o,
  output logic [NPAD-1:0]   pad_in_o,
  input  logic              tx_req_i,
  input  logic              rx_req_i,
  output logic              treq_o,
  output logic              treq_oe_o,
  output logic              rreq_o,
  output logic              rreq_oe_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic [ADDR_W-1:0] addr_o
);
  ctrl_t             ctrl_q;
  logic [NPAD-1:0]   dir_q, data_q, pad_s;
  logic [ADDR_W-1:0] ad_s, latch_w;
  logic              as_act_w;
  logic [1:0]        req_w, req_oe_w;

  hbf_cfg_regs #(.NPAD(NPAD), .CFG_DW(CFG_DW)) i_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i),
    .ctrl_o(ctrl_q), .dir_o(dir_q), .data_o(data_q)
  );

  hbf_sync #(.W(NPAD)) i_sync_pad (
    .clk_i, .rst_ni, .d_i(pad_i), .q_o(pad_s)
  );

  hbf_sync #(.W(ADDR_W)) i_sync_ad (
    .clk_i, .rst_ni, .d_i(ad_lo_i), .q_o(ad_s)
  );

  hbf_strobe_decode #(.ADDR_W(ADDR_W)) i_dec (
    .clk_i, .rst_ni,
    .port_en_i(ctrl_q.port_en), .cs_pol_i(ctrl_q.cs_pol),
    .as_pol_i(ctrl_q.as_pol), .ds_pol_i(ctrl_q.ds_pol),
    .dual_i(ctrl_q.dual), .mux_i(ctrl_q.mux),
    .pad_s_i(pad_s), .ad_s_i(ad_s),
    .rd_o, .wr_o, .addr_o,
    .latch_o(latch_w), .as_act_o(as_act_w)
  );

  hbf_req_drive #(.NLINE(2)) i_req (
    .port_en_i(ctrl_q.port_en), .req_en_i(ctrl_q.req_en),
    .req_od_i(ctrl_q.req_od), .dbl_req_i(ctrl_q.dbl_req),
    .tx_req_i, .rx_req_i,
    .req_o(req_w), .req_oe_o(req_oe_w)
  );

  assign treq_o    = req_w[0];
  assign treq_oe_o = req_oe_w[0];
  assign rreq_o    = req_w[1];
  assign rreq_oe_o = req_oe_w[1];

  // general-purpose fallback when the port is off
  assign pad_oe_o = ctrl_q.port_en ? '0 : dir_q;
  assign pad_o    = ctrl_q.port_en ? '0 : data_q;
  assign pad_in_o = pad_s;
endmodule

// File: rtl/hbf_checker.sv
module hbf_checker #(
  parameter int ADDR_W = 3,
  parameter int NPAD   = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              port_en_i,
  input logic              req_en_i,
  input logic              req_od_i,
  input logic              dbl_req_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [NPAD-1:0]   pad_oe_i,
  input logic              treq_i,
  input logic              treq_oe_i,
  input logic              rreq_i,
  input logic              rreq_oe_i,
  input logic [ADDR_W-1:0] latch_i,
  input logic              as_act_i
);
  a_r6_rd_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> !rd_i);
  a_r6_wr_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !wr_i);
  a_r3_rd_wr_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && wr_i));
  a_r12_no_pulse_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_en_i |=> !rd_i && !wr_i);
  a_r12_pads_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_en_i |-> pad_oe_i == '0);
  a_r9_req_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(port_en_i && req_en_i) |-> !treq_oe_i && !rreq_oe_i);
  a_r10_od_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_od_i |-> !treq_i && !rreq_i);
  a_r11_single_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dbl_req_i |-> !rreq_oe_i);
  a_r8_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !as_act_i |=> $stable(latch_i));
endmodule

bind host_bus_frontend hbf_checker #(.ADDR_W(ADDR_W), .NPAD(NPAD)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .port_en_i(ctrl_q.port_en), .req_en_i(ctrl_q.req_en),
  .req_od_i(ctrl_q.req_od), .dbl_req_i(ctrl_q.dbl_req),
  .rd_i(rd_o), .wr_i(wr_o), .pad_oe_i(pad_oe_o),
  .treq_i(treq_o), .treq_oe_i(treq_oe_o),
  .rreq_i(rreq_o), .rreq_oe_i(rreq_oe_o),
  .latch_i(latch_w), .as_act_i(as_act_w)
);

// File: tb/test_host_bus_frontend.sv
`timescale 1ns/1ps
module test_host_bus_frontend;
  localparam int AW  = 3;
  localparam int NP  = 5 + AW;
  localparam int CDW = (NP > 9) ? NP : 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [CDW-1:0] cfg_wd = '0;
  logic [NP-1:0] pad = '0;
  logic [AW-1:0] ad = '0;
  logic tx = 1'b0, rx = 1'b0;
  logic [NP-1:0] pad_o, pad_oe, pad_in;
  logic treq, treq_oe, rreq, rreq_oe, rd, wr;
  logic [AW-1:0] addr;

  always #4 clk = ~clk;

  host_bus_frontend #(.ADDR_W(AW)) i_host_bus_frontend (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wd),
    .pad_i(pad), .ad_lo_i(ad),
    .pad_o(pad_o), .pad_oe_o(pad_oe), .pad_in_o(pad_in),
    .tx_req_i(tx), .rx_req_i(rx),
    .treq_o(treq), .treq_oe_o(treq_oe), .rreq_o(rreq), .rreq_oe_o(rreq_oe),
    .rd_o(rd), .wr_o(wr), .addr_o(addr)
  );

  int n_cmp = 0, n_bad = 0;
  int n_rd = 0, n_wr = 0;
  string phase = "R1";
  bit done = 1'b0;

  // reference model state
  logic [8:0]    m_ctrl;
  logic [NP-1:0] m_dir, m_data, m_d1, m_d2;
  logic [AW-1:0] m_a1, m_a2, m_latch, m_addr;
  logic          m_rdq, m_wrq, m_rd, m_wr;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s (%s phase %s) at %0t: actual %0h expected %0h", req, what, phase, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    logic en, cs, ds, ws, ra, wa;
    logic drive, od, dbl, a0, oe0, o0, oe1, o1;
    if (!rst_n) begin
      m_ctrl = '0; m_dir = '0; m_data = '0; m_d1 = '0; m_d2 = '0;
      m_a1 = '0; m_a2 = '0; m_latch = '0; m_addr = '0;
      m_rdq = 0; m_wrq = 0; m_rd = 0; m_wr = 0;
    end else begin
      en = m_ctrl[0];
      cs = en && (m_d2[0] == m_ctrl[1]);
      ds = (m_d2[2] == m_ctrl[3]);
      ws = (m_d2[3] == m_ctrl[3]);
      ra = m_ctrl[4] ? (cs && ds) : (cs && ds && m_d2[4]);
      wa = m_ctrl[4] ? (cs && ws) : (cs && ds && !m_d2[4]);
      m_rd = ra && !m_rdq;
      m_wr = wa && !m_wrq;
      if (m_rd || m_wr) m_addr = m_ctrl[5] ? m_latch : m_d2[NP-1:5];
      if (en && m_ctrl[5] && (m_d2[1] == m_ctrl[2])) m_latch = m_a2;
      m_rdq = ra; m_wrq = wa;
      m_d2 = m_d1; m_d1 = pad; m_a2 = m_a1; m_a1 = ad;
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: m_ctrl = cfg_wd[8:0];
          2'd1: m_dir  = cfg_wd[NP-1:0];
          2'd2: m_data = cfg_wd[NP-1:0];
          default: ;
        endcase
      end
    end
    #2;
    if (rst_n) begin
      en = m_ctrl[0];
      drive = en && m_ctrl[7]; od = m_ctrl[6]; dbl = m_ctrl[8];
      a0  = dbl ? tx : (tx || rx);
      oe0 = drive && (od ? a0 : 1'b1);
      o0  = drive && !od && !a0;
      oe1 = drive && dbl && (od ? rx : 1'b1);
      o1  = drive && dbl && !od && !rx;
      if (rd) n_rd++;
      if (wr) n_wr++;
      chk("R6", "rd_o", rd, m_rd);
      chk("R6", "wr_o", wr, m_wr);
      chk("R7", "addr_o", addr, m_addr);
      chk("R12", "pad_oe_o", pad_oe, en ? '0 : m_dir);
      chk("R12", "pad_o", pad_o, en ? '0 : m_data);
      chk("R12", "pad_in_o", pad_in, m_d2);
      chk("R9", "treq_oe_o", treq_oe, oe0);
      chk("R9", "treq_o", treq, o0);
      chk("R11", "rreq_oe_o", rreq_oe, oe1);
      chk("R10", "rreq_o", rreq, o1);
    end
  end

  logic p_cs, p_as, p_ds, dual_m;

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wcfg(logic [1:0] sel, logic [CDW-1:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = sel; cfg_wd = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic drive_pads(bit c, bit a, bit s, bit w, bit dir, logic [AW-1:0] ad_pins);
    pad = {ad_pins, dir, (w ? p_ds : ~p_ds), (s ? p_ds : ~p_ds), (a ? p_as : ~p_as), (c ? p_cs : ~p_cs)};
  endtask

  // disable, set idle pins for the new polarities, then enable (R13 layout)
  task automatic mode(logic [8:0] c);
    wcfg(2'd0, CDW'(c & 9'h1FE));
    p_cs = c[1]; p_as = c[2]; p_ds = c[3]; dual_m = c[4];
    @(negedge clk); drive_pads(0, 0, 0, 0, 1, '0);
    cyc(3);
    wcfg(2'd0, CDW'(c));
    cyc(2);
  endtask

  task automatic access(bit is_rd, logic [AW-1:0] a, bit with_cs);
    @(negedge clk); drive_pads(with_cs, 0, 0, 0, is_rd, a);
    cyc(1);
    if (dual_m) drive_pads(with_cs, 0, is_rd, !is_rd, 1'b0, a);
    else        drive_pads(with_cs, 0, 1, 0, is_rd, a);
    cyc(4);
    drive_pads(with_cs, 0, 0, 0, is_rd, a);
    cyc(1);
    drive_pads(0, 0, 0, 0, 1, a);
    cyc(4);
  endtask

  task automatic addr_phase(logic [AW-1:0] v);
    @(negedge clk); ad = v; drive_pads(0, 1, 0, 0, 1, '0);
    cyc(3);
    drive_pads(0, 0, 0, 0, 1, '0);
    cyc(1); ad = ~v;  // bus reused for data after the address phase
    cyc(3);
  endtask

  task automatic cnt_chk(string req, int rd0, int wr0, int erd, int ewr);
    chk(req, "read pulse count", n_rd - rd0, erd);
    chk(req, "write pulse count", n_wr - wr0, ewr);
  endtask

  initial begin
    #200000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int r0, w0;
    p_cs = 0; p_as = 0; p_ds = 0; dual_m = 0;
    cyc(3);
    rst_n = 1;
    // R1: reset state
    cyc(1);
    chk("R1", "pad_oe_o", pad_oe, '0);
    chk("R1", "rd_o/wr_o", {rd, wr}, 2'b00);
    chk("R1", "req enables", {treq_oe, rreq_oe}, 2'b00);
    chk("R1", "addr_o", addr, '0);

    // R12 / R13: general-purpose fallback while disabled
    phase = "R12";
    wcfg(2'd1, CDW'(8'h0F));
    wcfg(2'd2, CDW'(8'hA5));
    wcfg(2'd3, CDW'(8'hFF));  // R13: code 3 writes nothing
    r0 = n_rd; w0 = n_wr;
    @(negedge clk); pad = 8'b0000_0000; cyc(3);
    @(negedge clk); pad = 8'b0001_1110; cyc(4);
    pad = 8'b0000_0100; cyc(4);
    tx = 1; rx = 1; cyc(3);
    chk("R12", "pad_oe_o", pad_oe, 8'h0F);
    chk("R13", "pad_o", pad_o, 8'hA5);
    cnt_chk("R12", r0, w0, 0, 0);
    tx = 0; rx = 0;

    // R3 / R2 / R5: single strobe, low-active chip select and strobes
    phase = "R3";
    mode(9'h001);
    r0 = n_rd; w0 = n_wr;
    access(1, 3'd5, 1);
    access(0, 3'd2, 1);
    cnt_chk("R3", r0, w0, 1, 1);
    chk("R7", "addr_o", addr, 3'd2);
    phase = "R2";
    r0 = n_rd; w0 = n_wr;
    access(1, 3'd7, 0);
    cnt_chk("R2", r0, w0, 0, 0);

    // R5 / R2: high-active chip select and strobe
    phase = "R5";
    mode(9'h00B);
    r0 = n_rd; w0 = n_wr;
    access(0, 3'd6, 1);
    access(1, 3'd1, 1);
    access(1, 3'd4, 0);
    cnt_chk("R5", r0, w0, 1, 1);

    // R4: dual strobe, both polarities
    phase = "R4";
    mode(9'h011);
    r0 = n_rd; w0 = n_wr;
    access(1, 3'd3, 1);
    access(0, 3'd4, 1);
    access(0, 3'd0, 1);
    cnt_chk("R4", r0, w0, 1, 2);
    mode(9'h01B);
    r0 = n_rd; w0 = n_wr;
    access(1, 3'd6, 1);
    cnt_chk("R4", r0, w0, 1, 0);

    // R8: multiplexed address, low- then high-active address strobe
    phase = "R8";
    mode(9'h021);
    addr_phase(3'd6);
    access(1, 3'd1, 1);
    chk("R8", "addr_o", addr, 3'd6);
    addr_phase(3'd3);
    access(0, 3'd7, 1);
    chk("R8", "addr_o", addr, 3'd3);
    mode(9'h025);
    addr_phase(3'd5);
    access(1, 3'd0, 1);
    chk("R8", "addr_o", addr, 3'd5);

    // R9 / R10 / R11: request drive
    phase = "R9";
    mode(9'h081);
    foreach (tx_seq[i]) begin
      {tx, rx} = tx_seq[i]; cyc(2);
    end
    phase = "R10";
    mode(9'h0C1);
    foreach (tx_seq[i]) begin
      {tx, rx} = tx_seq[i]; cyc(2);
    end
    phase = "R11";
    mode(9'h181);
    foreach (tx_seq[i]) begin
      {tx, rx} = tx_seq[i]; cyc(2);
    end
    mode(9'h1C1);
    foreach (tx_seq[i]) begin
      {tx, rx} = tx_seq[i]; cyc(2);
    end
    chk("R11", "rreq_oe_o", rreq_oe, 1'b1);
    // request enable without port enable stays released
    phase = "R9";
    wcfg(2'd0, CDW'(9'h180));
    cyc(2);
    chk("R9", "req enables", {treq_oe, rreq_oe}, 2'b00);
    tx = 0; rx = 0;

    // R12: disabling returns pins to general-purpose use
    phase = "R12";
    cyc(2);
    chk("R12", "pad_oe_o", pad_oe, 8'h0F);

    done = 1;
    cyc(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  logic [1:0] tx_seq [4] = '{2'b00, 2'b10, 2'b01, 2'b11};
endmodule